// File: doc/BRIEF.md
# Store-Release Write Tracker

This block sits on the store path of one compute unit. Every ordinary store is taken into a small write cache that keeps, for each block, only the bytes actually written (a per-byte valid mask), so a store never needs the block's old contents from below. Stores from different wavefronts that hit the same block merge in place. Alongside the cache, an ordering queue records the block address of every store in program order.

Draining is lazy. Blocks are written through to the next memory level, one at a time, only when the cache is full, when the ordering queue is full, or when a release is waiting. A store-release places a marker in the ordering queue behind all earlier stores. Its own write is sent downstream only after every write ahead of the marker has been acknowledged. A single-cycle done pulse then reports completion. Ordinary stores keep flowing while a release waits; only the release itself, and a second release, are held. A load port looks up the cache and returns the locally written bytes of a block that has not yet drained.

Top module: `wr_sync_tracker`

## Requirements
- R1: After reset, dn_valid, rel_done and ld_hit are 0, and st_ready and rel_ready are 1.
- R2: A store to a block already held sets only the bytes whose st_be bit is 1 (byte i is st_data[8i+7:8i]) and keeps the other bytes. A load of a held block returns ld_hit=1, the union of the written bytes as ld_mask, and those bytes in ld_data.
- R3: All stores to a block that is still held reach the next level as one downstream write carrying the merged bytes.
- R4: Downstream writes leave in the order of the oldest queued store to each block. A queue entry whose block has already been written out is dropped without a second write.
- R5: No downstream write starts unless the cache is full, the ordering queue is full, or a release is waiting in the queue.
- R6: The release write (dn_is_rel=1, carrying rel_addr, rel_be and rel_data) is sent only after every store queued before it has been written and acknowledged.
- R7: rel_done is high for exactly one cycle, the cycle after the release write's acknowledge. rel_ready stays 0 from a release's acceptance until its rel_done.
- R8: Each downstream write holds dn_valid and its fields stable until dn_ack. Only one write is outstanding. dn_mask is the tracked byte mask, and bytes whose mask bit is 0 read as zero in dn_data.
- R9: A block's cache entry is freed when its write is acknowledged, so a later load of that block gives ld_hit=0.
- R10: When every cache entry holds a block, the oldest queued block is written out, and a store to a new block waits until an entry is free.
- R11: Ordinary stores to other blocks are accepted while a release is pending, and do not wait for its rel_done.
- R12: A store to the block whose write is in flight is held (st_ready=0) until that write is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | ADDR_W | Store block address |
| st_be | input | BLK_BYTES | Store byte enables |
| st_data | input | BLK_BYTES*8 | Store data, byte i in bits 8i+7:8i |
| rel_valid | input | 1 | Store-release request present |
| rel_ready | output | 1 | Release accepted this cycle when high with rel_valid |
| rel_addr | input | ADDR_W | Release block address |
| rel_be | input | BLK_BYTES | Release byte enables |
| rel_data | input | BLK_BYTES*8 | Release data |
| rel_done | output | 1 | One-cycle pulse: release write acknowledged |
| ld_addr | input | ADDR_W | Load lookup block address |
| ld_hit | output | 1 | Block held in write cache |
| ld_mask | output | BLK_BYTES | Locally written bytes |
| ld_data | output | BLK_BYTES*8 | Locally written data |
| dn_valid | output | 1 | Downstream write present |
| dn_addr | output | ADDR_W | Downstream block address |
| dn_mask | output | BLK_BYTES | Downstream byte mask |
| dn_data | output | BLK_BYTES*8 | Downstream data |
| dn_is_rel | output | 1 | Downstream write is the release store |
| dn_ack | input | 1 | Downstream acknowledge of the present write |

## Verification
The bench builds the block with 16-byte blocks, a 4-entry write cache, an 8-deep ordering queue and 12-bit addresses. Four distinct stores then fill the cache, and eight stores to one block fill the queue. Both lazy drain triggers and the dropping of stale queue entries are therefore reached in a few dozen cycles. A responder with adjustable acknowledge latency keeps a release or an in-flight block pending long enough to probe stores that proceed past a release and stores held on the in-flight block.

// File: rtl/wst_pkg.sv
package wst_pkg;
  typedef enum logic {
    DS_IDLE = 1'b0,
    DS_WAIT = 1'b1
  } drain_state_e;

  typedef enum logic {
    EK_WRITE   = 1'b0,
    EK_RELEASE = 1'b1
  } entry_kind_e;
endpackage

// File: rtl/wst_cache.sv
module wst_cache #(
  parameter int ADDR_W    = 26,
  parameter int BLK_BYTES = 64,
  parameter int ENTRIES   = 8,
  localparam int DATA_W   = BLK_BYTES * 8,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 st_we,
  input  logic [ADDR_W-1:0]    st_addr,
  input  logic [BLK_BYTES-1:0] st_be,
  input  logic [DATA_W-1:0]    st_data,
  output logic                 st_hit,
  output logic                 full,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  input  logic [ADDR_W-1:0]    drn_addr,
  output logic                 drn_hit,
  output logic [IDX_W-1:0]     drn_idx,
  output logic [BLK_BYTES-1:0] drn_mask,
  output logic [DATA_W-1:0]    drn_data,
  input  logic [ADDR_W-1:0]    ld_addr,
  output logic                 ld_hit,
  output logic [BLK_BYTES-1:0] ld_mask,
  output logic [DATA_W-1:0]    ld_data
);
  function automatic logic [DATA_W-1:0] byte_fill(input logic [BLK_BYTES-1:0] m);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < BLK_BYTES; b++) r[b*8 +: 8] = {8{m[b]}};
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] byte_merge(input logic [DATA_W-1:0] old_d,
                                                   input logic [DATA_W-1:0] new_d,
                                                   input logic [BLK_BYTES-1:0] be);
    logic [DATA_W-1:0] f;
    f = byte_fill(be);
    return (old_d & ~f) | (new_d & f);
  endfunction

  logic [ADDR_W-1:0]    tag_q  [ENTRIES];
  logic [BLK_BYTES-1:0] mask_q [ENTRIES];
  logic [DATA_W-1:0]    data_q [ENTRIES];
  logic [ENTRIES-1:0]   vld_q;

  logic             free_ok;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] st_idx;
  logic [IDX_W-1:0] ld_idx;

  always_comb begin
    st_hit   = 1'b0;
    st_idx   = '0;
    drn_hit  = 1'b0;
    drn_idx  = '0;
    ld_hit   = 1'b0;
    ld_idx   = '0;
    free_ok  = 1'b0;
    free_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!vld_q[e]) begin
        free_ok  = 1'b1;
        free_idx = IDX_W'(e);
      end
      if (vld_q[e] && tag_q[e] == st_addr) begin
        st_hit = 1'b1;
        st_idx = IDX_W'(e);
      end
      if (vld_q[e] && tag_q[e] == drn_addr) begin
        drn_hit = 1'b1;
        drn_idx = IDX_W'(e);
      end
      if (vld_q[e] && tag_q[e] == ld_addr) begin
        ld_hit = 1'b1;
        ld_idx = IDX_W'(e);
      end
    end
  end

  assign full     = !free_ok;
  assign drn_mask = mask_q[drn_idx];
  assign drn_data = data_q[drn_idx];
  assign ld_mask  = ld_hit ? mask_q[ld_idx] : '0;
  assign ld_data  = ld_hit ? data_q[ld_idx] : '0;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[e]  <= 1'b0;
        tag_q[e]  <= '0;
        mask_q[e] <= '0;
        data_q[e] <= '0;
      end else if (clr_en && clr_idx == IDX_W'(e)) begin
        vld_q[e]  <= 1'b0;
        mask_q[e] <= '0;
        data_q[e] <= '0;
      end else if (st_we && st_hit && st_idx == IDX_W'(e)) begin
        mask_q[e] <= mask_q[e] | st_be;
        data_q[e] <= byte_merge(data_q[e], st_data, st_be);
      end else if (st_we && !st_hit && free_ok && free_idx == IDX_W'(e)) begin
        vld_q[e]  <= 1'b1;
        tag_q[e]  <= st_addr;
        mask_q[e] <= st_be;
        data_q[e] <= st_data & byte_fill(st_be);
      end
    end
  end
endmodule

// File: rtl/wst_order_fifo.sv
module wst_order_fifo
  import wst_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  entry_kind_e       push_kind,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output entry_kind_e       head_kind,
  output logic [ADDR_W-1:0] head_addr,
  output logic              empty,
  output logic              full
);
  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  entry_kind_e       kind_q [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [PTR_W-1:0]  rd_q, wr_q;
  logic [CNT_W-1:0]  cnt_q;

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign head_kind = kind_q[rd_q];
  assign head_addr = addr_q[rd_q];

  logic do_push, do_pop;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        kind_q[i] <= EK_WRITE;
        addr_q[i] <= '0;
      end
    end else begin
      if (do_push) begin
        kind_q[wr_q] <= push_kind;
        addr_q[wr_q] <= push_addr;
        wr_q         <= ptr_next(wr_q);
      end
      if (do_pop) rd_q <= ptr_next(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CNT_W'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/wst_drain_ctrl.sv
module wst_drain_ctrl
  import wst_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int BLK_BYTES = 64,
  parameter int ENTRIES   = 8,
  localparam int DATA_W   = BLK_BYTES * 8,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trigger,
  input  logic                 q_empty,
  input  entry_kind_e          head_kind,
  input  logic [ADDR_W-1:0]    head_addr,
  input  logic                 drn_hit,
  input  logic [IDX_W-1:0]     drn_idx,
  input  logic [BLK_BYTES-1:0] drn_mask,
  input  logic [DATA_W-1:0]    drn_data,
  input  logic [ADDR_W-1:0]    rel_addr,
  input  logic [BLK_BYTES-1:0] rel_mask,
  input  logic [DATA_W-1:0]    rel_data,
  input  logic                 dn_ack,
  output logic                 q_pop,
  output logic                 clr_en,
  output logic [IDX_W-1:0]     clr_idx,
  output logic                 issue_wr_now,
  output logic                 in_flight,
  output logic [ADDR_W-1:0]    dn_addr,
  output logic [BLK_BYTES-1:0] dn_mask,
  output logic [DATA_W-1:0]    dn_data,
  output logic                 dn_is_rel,
  output logic                 rel_done,
  output logic                 marker_popped
);
  drain_state_e         state_q;
  logic [IDX_W-1:0]     idx_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [BLK_BYTES-1:0] mask_q;
  logic [DATA_W-1:0]    data_q;
  logic                 rel_q;
  logic                 done_q;

  logic can_act, issue_rel_now, skip_now, ack_now;
  assign can_act       = (state_q == DS_IDLE) && trigger && !q_empty;
  assign issue_rel_now = can_act && (head_kind == EK_RELEASE);
  assign issue_wr_now  = can_act && (head_kind == EK_WRITE) && drn_hit;
  assign skip_now      = can_act && (head_kind == EK_WRITE) && !drn_hit;
  assign ack_now       = (state_q == DS_WAIT) && dn_ack;

  assign q_pop         = skip_now || ack_now;
  assign clr_en        = ack_now && !rel_q;
  assign clr_idx       = idx_q;
  assign marker_popped = ack_now && rel_q;
  assign in_flight     = (state_q == DS_WAIT);
  assign dn_addr       = addr_q;
  assign dn_mask       = mask_q;
  assign dn_data       = data_q;
  assign dn_is_rel     = rel_q;
  assign rel_done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= DS_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
      mask_q  <= '0;
      data_q  <= '0;
      rel_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= ack_now && rel_q;
      if (issue_rel_now) begin
        state_q <= DS_WAIT;
        addr_q  <= rel_addr;
        mask_q  <= rel_mask;
        data_q  <= rel_data;
        rel_q   <= 1'b1;
      end else if (issue_wr_now) begin
        state_q <= DS_WAIT;
        idx_q   <= drn_idx;
        addr_q  <= head_addr;
        mask_q  <= drn_mask;
        data_q  <= drn_data;
        rel_q   <= 1'b0;
      end else if (ack_now) begin
        state_q <= DS_IDLE;
        rel_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wr_sync_tracker.sv
module wr_sync_tracker
  import wst_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int BLK_BYTES  = 64,
  parameter int ENTRIES    = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int DATA_W    = BLK_BYTES * 8,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 st_valid,
  output logic                 st_ready,
  input  logic [ADDR_W-1:0]    st_addr,
  input  logic [BLK_BYTES-1:0] st_be,
  input  logic [DATA_W-1:0]    st_data,
  input  logic                 rel_valid,
  output logic                 rel_ready,
  input  logic [ADDR_W-1:0]    rel_addr,
  input  logic [BLK_BYTES-1:0] rel_be,
  input  logic [DATA_W-1:0]    rel_data,
  output logic                 rel_done,
  input  logic [ADDR_W-1:0]    ld_addr,
  output logic                 ld_hit,
  output logic [BLK_BYTES-1:0] ld_mask,
  output logic [DATA_W-1:0]    ld_data,
  output logic                 dn_valid,
  output logic [ADDR_W-1:0]    dn_addr,
  output logic [BLK_BYTES-1:0] dn_mask,
  output logic [DATA_W-1:0]    dn_data,
  output logic                 dn_is_rel,
  input  logic                 dn_ack
);
  function automatic logic [DATA_W-1:0] keep_bytes(input logic [DATA_W-1:0] d,
                                                   input logic [BLK_BYTES-1:0] m);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < BLK_BYTES; b++) r[b*8 +: 8] = m[b] ? d[b*8 +: 8] : 8'h00;
    return r;
  endfunction

  // named internal events, observed by the bound checker
  logic st_fire, rel_fire, st_conflict, cache_full, fifo_full, drain_trigger;
  logic rel_busy_q, rel_queued_q;

  logic                 st_hit, drn_hit, q_empty, q_pop, clr_en;
  logic                 issue_wr_now, in_flight, marker_popped;
  logic [IDX_W-1:0]     drn_idx, clr_idx;
  logic [BLK_BYTES-1:0] drn_mask;
  logic [DATA_W-1:0]    drn_data;
  entry_kind_e          head_kind;
  logic [ADDR_W-1:0]    head_addr;

  logic [ADDR_W-1:0]    rel_addr_q;
  logic [BLK_BYTES-1:0] rel_mask_q;
  logic [DATA_W-1:0]    rel_data_q;

  assign st_conflict = (in_flight && !dn_is_rel && st_addr == dn_addr) ||
                       (issue_wr_now && st_addr == head_addr);
  assign st_ready    = !st_conflict && !fifo_full && (st_hit || !cache_full);
  assign st_fire     = st_valid && st_ready;
  assign rel_ready   = !rel_busy_q && !fifo_full && !st_valid;
  assign rel_fire    = rel_valid && rel_ready;
  assign drain_trigger = cache_full || fifo_full || rel_queued_q;
  assign dn_valid    = in_flight;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_busy_q   <= 1'b0;
      rel_queued_q <= 1'b0;
      rel_addr_q   <= '0;
      rel_mask_q   <= '0;
      rel_data_q   <= '0;
    end else begin
      if (rel_fire) begin
        rel_busy_q   <= 1'b1;
        rel_queued_q <= 1'b1;
        rel_addr_q   <= rel_addr;
        rel_mask_q   <= rel_be;
        rel_data_q   <= keep_bytes(rel_data, rel_be);
      end else begin
        if (marker_popped) rel_queued_q <= 1'b0;
        if (rel_done)      rel_busy_q   <= 1'b0;
      end
    end
  end

  wst_cache #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .ENTRIES(ENTRIES)) cache_i (
    .clk(clk), .rst_n(rst_n),
    .st_we(st_fire), .st_addr(st_addr), .st_be(st_be), .st_data(st_data),
    .st_hit(st_hit), .full(cache_full),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .drn_addr(head_addr), .drn_hit(drn_hit), .drn_idx(drn_idx),
    .drn_mask(drn_mask), .drn_data(drn_data),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_mask(ld_mask), .ld_data(ld_data)
  );

  wst_order_fifo #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH)) order_i (
    .clk(clk), .rst_n(rst_n),
    .push(st_fire || rel_fire),
    .push_kind(st_fire ? EK_WRITE : EK_RELEASE),
    .push_addr(st_fire ? st_addr : rel_addr),
    .pop(q_pop), .head_kind(head_kind), .head_addr(head_addr),
    .empty(q_empty), .full(fifo_full)
  );

  wst_drain_ctrl #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .ENTRIES(ENTRIES)) drain_i (
    .clk(clk), .rst_n(rst_n),
    .trigger(drain_trigger), .q_empty(q_empty),
    .head_kind(head_kind), .head_addr(head_addr),
    .drn_hit(drn_hit), .drn_idx(drn_idx), .drn_mask(drn_mask), .drn_data(drn_data),
    .rel_addr(rel_addr_q), .rel_mask(rel_mask_q), .rel_data(rel_data_q),
    .dn_ack(dn_ack),
    .q_pop(q_pop), .clr_en(clr_en), .clr_idx(clr_idx),
    .issue_wr_now(issue_wr_now), .in_flight(in_flight),
    .dn_addr(dn_addr), .dn_mask(dn_mask), .dn_data(dn_data), .dn_is_rel(dn_is_rel),
    .rel_done(rel_done), .marker_popped(marker_popped)
  );
endmodule

// File: rtl/wst_checker.sv
module wst_checker #(
  parameter int ADDR_W    = 26,
  parameter int BLK_BYTES = 64,
  localparam int DATA_W   = BLK_BYTES * 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 st_valid,
  input logic                 st_ready,
  input logic [ADDR_W-1:0]    st_addr,
  input logic                 rel_ready,
  input logic                 rel_done,
  input logic                 rel_busy,
  input logic                 cache_full,
  input logic                 fifo_full,
  input logic                 st_conflict,
  input logic                 dn_valid,
  input logic [ADDR_W-1:0]    dn_addr,
  input logic [BLK_BYTES-1:0] dn_mask,
  input logic [DATA_W-1:0]    dn_data,
  input logic                 dn_is_rel,
  input logic                 dn_ack
);
  function automatic logic [DATA_W-1:0] unset_bytes(input logic [DATA_W-1:0] d,
                                                    input logic [BLK_BYTES-1:0] m);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < BLK_BYTES; b++) r[b*8 +: 8] = m[b] ? 8'h00 : d[b*8 +: 8];
    return r;
  endfunction

  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ack) |=> (dn_valid && $stable(dn_addr) && $stable(dn_mask) &&
                               $stable(dn_data) && $stable(dn_is_rel)));

  a_r8_unmasked_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (unset_bytes(dn_data, dn_mask) == '0));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rel_done |=> !rel_done);

  a_r7_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rel_done |-> $past(dn_valid && dn_ack && dn_is_rel));

  a_r7_one_release: assert property (@(posedge clk) disable iff (!rst_n)
    rel_busy |-> !rel_ready);

  a_r11_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |-> (cache_full || fifo_full || st_conflict));

  a_r12_inflight_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_is_rel && st_valid && st_addr == dn_addr) |-> !st_ready);
endmodule

bind wr_sync_tracker wst_checker #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
  .rel_ready(rel_ready), .rel_done(rel_done), .rel_busy(rel_busy_q),
  .cache_full(cache_full), .fifo_full(fifo_full), .st_conflict(st_conflict),
  .dn_valid(dn_valid), .dn_addr(dn_addr), .dn_mask(dn_mask), .dn_data(dn_data),
  .dn_is_rel(dn_is_rel), .dn_ack(dn_ack)
);

// File: tb/wr_sync_tracker_tb.sv
module wr_sync_tracker_tb_top;
  localparam int AW = 12;
  localparam int NB = 16;
  localparam int DW = NB * 8;
  localparam logic [AW-1:0] REL_A = 12'hF00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic st_valid = 0, rel_valid = 0, dn_ack = 0;
  logic [AW-1:0] st_addr = '0, rel_addr = '0, ld_addr = '0;
  logic [NB-1:0] st_be = '0, rel_be = '0;
  logic [DW-1:0] st_data = '0, rel_data = '0;
  logic st_ready, rel_ready, rel_done, ld_hit, dn_valid, dn_is_rel;
  logic [NB-1:0] ld_mask, dn_mask;
  logic [DW-1:0] ld_data, dn_data;
  logic [AW-1:0] dn_addr;

  wr_sync_tracker #(.ADDR_W(AW), .BLK_BYTES(NB), .ENTRIES(4), .FIFO_DEPTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_be(st_be), .st_data(st_data),
    .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_addr(rel_addr), .rel_be(rel_be),
    .rel_data(rel_data), .rel_done(rel_done),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_mask(ld_mask), .ld_data(ld_data),
    .dn_valid(dn_valid), .dn_addr(dn_addr), .dn_mask(dn_mask), .dn_data(dn_data),
    .dn_is_rel(dn_is_rel), .dn_ack(dn_ack)
  );

  int checks = 0, fails = 0;
  int ack_lat = 3;
  int log_n = 0;
  int done_cycles = 0;
  logic [AW-1:0] log_addr [64];
  logic [NB-1:0] log_mask [64];
  logic [DW-1:0] log_data [64];
  logic          log_rel  [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int s);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) r[b*8 +: 8] = 8'(s * 16 + b);
    return r;
  endfunction

  function automatic logic [DW-1:0] only(input logic [DW-1:0] d, input logic [NB-1:0] m);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) r[b*8 +: 8] = m[b] ? d[b*8 +: 8] : 8'h00;
    return r;
  endfunction

  // downstream responder: acknowledges after ack_lat cycles and logs each write
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (dn_ack) begin
        dn_ack = 1'b0;
      end else if (dn_valid) begin
        if (wait_cnt >= ack_lat) begin
          dn_ack = 1'b1;
          wait_cnt = 0;
          log_addr[log_n] = dn_addr;
          log_mask[log_n] = dn_mask;
          log_data[log_n] = dn_data;
          log_rel[log_n]  = dn_is_rel;
          chk(only(dn_data, ~dn_mask) == '0, "R8", "unmasked bytes zero",
              only(dn_data, ~dn_mask), '0);
          if (log_n < 63) log_n++;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  always @(negedge clk) if (rel_done) done_cycles++;

  task automatic do_store(input logic [AW-1:0] a, input logic [NB-1:0] be, input logic [DW-1:0] d);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_be = be; st_data = d;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic do_release(input int s);
    @(negedge clk);
    rel_valid = 1; rel_addr = REL_A; rel_be = 16'h0001; rel_data = pat(s);
    #1;
    while (!rel_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rel_valid = 0;
  endtask

  task automatic wait_done();
    int d0 = done_cycles;
    while (done_cycles == d0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_chk(input logic [AW-1:0] a, input bit hit, input logic [NB-1:0] m,
                          input logic [DW-1:0] d, input string req);
    @(negedge clk);
    ld_addr = a;
    #1;
    chk(ld_hit == hit, req, "ld_hit", DW'(ld_hit), DW'(hit));
    if (hit) begin
      chk(ld_mask == m, req, "ld_mask", DW'(ld_mask), DW'(m));
      chk(ld_data == d, req, "ld_data", ld_data, d);
    end
  endtask

  task automatic log_chk(input int i, input logic [AW-1:0] a, input logic [NB-1:0] m,
                         input logic [DW-1:0] d, input bit rel, input string req);
    chk(log_addr[i] == a, req, "dn_addr", DW'(log_addr[i]), DW'(a));
    chk(log_mask[i] == m, req, "dn_mask", DW'(log_mask[i]), DW'(m));
    chk(log_data[i] == d, req, "dn_data", log_data[i], d);
    chk(log_rel[i] == rel, req, "dn_is_rel", DW'(log_rel[i]), DW'(rel));
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(dn_valid == 0, "R1", "dn_valid", DW'(dn_valid), 0);
    chk(rel_done == 0, "R1", "rel_done", DW'(rel_done), 0);
    chk(ld_hit == 0, "R1", "ld_hit", DW'(ld_hit), 0);
    chk(st_ready == 1, "R1", "st_ready", DW'(st_ready), 1);
    chk(rel_ready == 1, "R1", "rel_ready", DW'(rel_ready), 1);
  endtask

  task automatic t_merge_raw();
    int b = log_n;
    logic [DW-1:0] exp_d = only(pat(1), 16'h000F) | only(pat(2), 16'h0F00);
    do_store(12'h010, 16'h000F, pat(1));
    do_store(12'h010, 16'h0F00, pat(2));
    load_chk(12'h010, 1, 16'h0F0F, exp_d, "R2");
    idle(20);
    chk(log_n == b, "R5", "writes without trigger", DW'(log_n - b), 0);
    do_release(9);
    wait_done();
    chk(log_n == b + 2, "R3", "write count", DW'(log_n - b), 2);
    log_chk(b, 12'h010, 16'h0F0F, exp_d, 0, "R3");
    log_chk(b + 1, REL_A, 16'h0001, only(pat(9), 16'h0001), 1, "R6");
    load_chk(12'h010, 0, '0, '0, "R9");
  endtask

  task automatic t_order_skip();
    int b = log_n;
    do_store(12'h020, 16'h0003, pat(3));
    do_store(12'h030, 16'h00F0, pat(4));
    do_store(12'h020, 16'h0030, pat(5));
    do_release(8);
    wait_done();
    chk(log_n == b + 3, "R4", "write count", DW'(log_n - b), 3);
    log_chk(b, 12'h020, 16'h0033, only(pat(3), 16'h0003) | only(pat(5), 16'h0030), 0, "R4");
    log_chk(b + 1, 12'h030, 16'h00F0, only(pat(4), 16'h00F0), 0, "R4");
    chk(log_rel[b + 2] == 1, "R6", "release last", DW'(log_rel[b + 2]), 1);
  endtask

  task automatic t_queue_full();
    int b = log_n;
    for (int i = 0; i < 8; i++) do_store(12'h040, NB'(1) << i, pat(6));
    idle(30);
    chk(log_n == b + 1, "R5", "queue-full drain count", DW'(log_n - b), 1);
    log_chk(b, 12'h040, 16'h00FF, only(pat(6), 16'h00FF), 0, "R5");
    do_release(7);
    wait_done();
    chk(log_n == b + 2, "R4", "stale entries skipped", DW'(log_n - b), 2);
    chk(log_rel[b + 1] == 1, "R4", "only release follows", DW'(log_rel[b + 1]), 1);
  endtask

  task automatic t_cache_full();
    int b = log_n;
    for (int i = 0; i < 4; i++) do_store(AW'(12'h050 + 16 * i), 16'hFFFF, pat(10 + i));
    idle(20);
    chk(log_n == b + 1, "R10", "one drain when full", DW'(log_n - b), 1);
    log_chk(b, 12'h050, 16'hFFFF, pat(10), 0, "R10");
    load_chk(12'h050, 0, '0, '0, "R9");
    load_chk(12'h060, 1, 16'hFFFF, pat(11), "R10");
    do_store(12'h090, 16'hFFFF, pat(14));
    idle(20);
    chk(log_n == b + 2, "R10", "second drain", DW'(log_n - b), 2);
    log_chk(b + 1, 12'h060, 16'hFFFF, pat(11), 0, "R10");
    do_release(6);
    wait_done();
    chk(log_n == b + 6, "R6", "flush count", DW'(log_n - b), 6);
    log_chk(b + 2, 12'h070, 16'hFFFF, pat(12), 0, "R4");
    log_chk(b + 3, 12'h080, 16'hFFFF, pat(13), 0, "R4");
    log_chk(b + 4, 12'h090, 16'hFFFF, pat(14), 0, "R4");
    chk(log_rel[b + 5] == 1, "R6", "release after all", DW'(log_rel[b + 5]), 1);
  endtask

  task automatic t_release_nonblocking();
    int b = log_n;
    int d0;
    ack_lat = 15;
    do_store(12'h0A0, 16'h0001, pat(1));
    do_store(12'h0B0, 16'h0002, pat(2));
    do_release(5);
    d0 = done_cycles;
    #1;
    chk(rel_ready == 0, "R7", "rel_ready while pending", DW'(rel_ready), 0);
    do_store(12'h0C0, 16'h0004, pat(3));
    chk(done_cycles == d0, "R11", "store accepted before rel_done", DW'(done_cycles - d0), 0);
    wait_done();
    chk(done_cycles == d0 + 1, "R7", "done pulse width", DW'(done_cycles - d0), 1);
    chk(log_n == b + 3, "R11", "write count", DW'(log_n - b), 3);
    log_chk(b, 12'h0A0, 16'h0001, only(pat(1), 16'h0001), 0, "R6");
    log_chk(b + 1, 12'h0B0, 16'h0002, only(pat(2), 16'h0002), 0, "R6");
    chk(log_rel[b + 2] == 1, "R6", "release third", DW'(log_rel[b + 2]), 1);
    load_chk(12'h0C0, 1, 16'h0004, only(pat(3), 16'h0004), "R11");
    ack_lat = 3;
    do_release(4);
    wait_done();
    log_chk(b + 3, 12'h0C0, 16'h0004, only(pat(3), 16'h0004), 0, "R11");
  endtask

  task automatic t_inflight_conflict();
    int b = log_n;
    ack_lat = 15;
    do_store(12'h0D0, 16'h0010, pat(2));
    do_release(3);
    while (!(dn_valid && !dn_is_rel)) @(negedge clk);
    st_valid = 1; st_addr = 12'h0D0; st_be = 16'h0020; st_data = pat(4);
    #1;
    chk(st_ready == 0, "R12", "store to in-flight block", DW'(st_ready), 0);
    @(negedge clk); #1;
    chk(st_ready == 0, "R12", "still held", DW'(st_ready), 0);
    st_valid = 0;
    wait_done();
    ack_lat = 3;
    log_chk(b, 12'h0D0, 16'h0010, only(pat(2), 16'h0010), 0, "R12");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_merge_raw();
    t_order_skip();
    t_queue_full();
    t_cache_full();
    t_release_nonblocking();
    t_inflight_conflict();
    idle(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule